// File: doc/BRIEF.md
# Converter Core Clock Divider and Sample Window Timer

This block sits between a fast peripheral clock and an analog-to-digital converter core. It does not build a second clock. It makes a one-cycle enable, `core_en`, that marks each edge of the slower core clock. The divide ratio comes from two stages in series. The first is a 4-bit prescaler: code 0 passes every peripheral clock, and a nonzero code N divides by 2N. The second is an optional fixed halving stage.

A single-cycle sample request opens a sampling window, `sample_win`, on a core-clock boundary. The window stays high, holding the sample switch closed, for the acquisition setting plus one core-clock periods. When it closes, `sample_done` pulses. A request that arrives while a window is open is remembered, and it reopens the window as soon as the current one ends.

Changes to the divider settings are taken only on a core-clock boundary. This means the enable never shows a shortened period.

Top module: `adcclk_sampler`

## Requirements
- R1: While `rst` is high, `core_en`, `sample_win` and `sample_done` are low.
- R2: With `pre_div` = 0 and `post_half` = 0, `core_en` is high in every clock cycle.
- R3: With `pre_div` = N (N from 1 to 15) and `post_half` = 0, `core_en` is a one-cycle pulse every 2N clock cycles.
- R4: `post_half` = 1 doubles the ratio of R2/R3. The ratio is 2 for code 0 and 4N for code N, up to 60.
- R5: Divider settings are sampled only at the clock edge where `core_en` rises. The interval that follows a pulse uses the values present at that pulse's edge, and a change made inside an interval first shows in the next one.
- R6: A window opens at a clock edge where `core_en` rises. It lasts (`acq_len` + 1) × ratio clock cycles.
- R7: `sample_done` is high for exactly one clock cycle, starting at the edge where a window ends. That edge coincides with a `core_en` pulse.
- R8: Requests made during an open window are merged into one pending request. At the ending boundary this request restarts the window with no idle gap, and `sample_done` still pulses.
- R9: `acq_len` is sampled when a window opens. Changing it while the window is open does not alter that window's length.
- R10: A request while idle opens the window at the first core boundary after it is sampled. When the request is driven right after a `core_en` pulse, `sample_win` rises exactly one ratio of clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_div | input | 4 | Prescale code: 0 bypasses, N divides by 2N |
| post_half | input | 1 | 1 adds a divide-by-2 after the prescaler |
| acq_len | input | 4 | Window length minus one, in core-clock periods |
| sample_req | input | 1 | Single-cycle sample request |
| core_en | output | 1 | One-cycle enable marking each core-clock edge |
| sample_win | output | 1 | High while the sample switch is closed |
| sample_done | output | 1 | One-cycle strobe when a window closes |

## Verification
Some properties are checked by assertions on every cycle:
- the prescale counter never passes its terminal count;
- the latched prescale code never moves between core boundaries;
- `sample_win` changes only one cycle after a core boundary, and it rises only together with `core_en`;
- `sample_done` always follows an open window.

Other behaviour can only be shown by the bench's directed scenarios, which measure cycle counts at the ports:
- the exact divide ratios;
- the one-interval delay before a new setting applies;
- the total window lengths;
- request merging and back-to-back restart;
- insensitivity to `acq_len` changes during a window.

// File: rtl/adcclk_pkg.sv
package adcclk_pkg;

  localparam int PRE_W_DEF = 4;
  localparam int ACQ_W_DEF = 4;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;

endpackage

// File: rtl/adcclk_prescale.sv
module adcclk_prescale #(
  parameter int PRE_W = adcclk_pkg::PRE_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PRE_W-1:0] pre_in,
  output logic             tick
);
  localparam int CW = PRE_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    ratio;

  assign ratio = (pre_q == '0) ? CW'(1) : {pre_q, 1'b0};
  assign tick  = (cnt == ratio - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pre_q <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (load) pre_q <= pre_in;
    end
  end

  // R3: counter stays inside the current ratio
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio);

  // R5: prescale code moves only on a core boundary
  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(pre_q));

endmodule

// File: rtl/adcclk_halver.sv
module adcclk_halver (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic half_in,
  input  logic tick_in,
  output logic tick_out
);
  logic half_q;
  logic phase;

  assign tick_out = tick_in & (~half_q | phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      phase  <= 1'b0;
    end else begin
      if (load) begin
        half_q <= half_in;
        phase  <= 1'b0;
      end else if (tick_in) begin
        phase <= ~phase;
      end
    end
  end

endmodule

// File: rtl/adcclk_window.sv
module adcclk_window #(
  parameter int ACQ_W = adcclk_pkg::ACQ_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ACQ_W-1:0] acq_in,
  input  logic             req,
  output logic             win,
  output logic             done
);
  import adcclk_pkg::*;

  win_state_t       state;
  logic [ACQ_W-1:0] left;
  logic             pend;
  logic             want;

  assign want = pend | req;
  assign win  = (state == WIN_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WIN_IDLE;
      left  <= '0;
      pend  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      pend <= want;
      if (tick) begin
        if (state == WIN_IDLE) begin
          if (want) begin
            state <= WIN_OPEN;
            left  <= acq_in;
            pend  <= 1'b0;
          end
        end else if (left == '0) begin
          done <= 1'b1;
          pend <= 1'b0;
          if (want) left <= acq_in;
          else      state <= WIN_IDLE;
        end else begin
          left <= left - ACQ_W'(1);
        end
      end
    end
  end

  // R6: window edges fall only after a core boundary
  a_r6_win_on_tick: assert property (@(posedge clk) disable iff (rst)
    (win != $past(win)) |-> $past(tick));

  // R7: completion only follows an open window
  a_r7_done_after_win: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(win));

endmodule

// File: rtl/adcclk_sampler.sv
module adcclk_sampler #(
  parameter int PRE_W = adcclk_pkg::PRE_W_DEF,
  parameter int ACQ_W = adcclk_pkg::ACQ_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_div,
  input  logic             post_half,
  input  logic [ACQ_W-1:0] acq_len,
  input  logic             sample_req,
  output logic             core_en,
  output logic             sample_win,
  output logic             sample_done
);
  logic tick_pre;
  logic tick_core;

  adcclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .load   (tick_core),
    .pre_in (pre_div),
    .tick   (tick_pre)
  );

  adcclk_halver u_half (
    .clk      (clk),
    .rst      (rst),
    .load     (tick_core),
    .half_in  (post_half),
    .tick_in  (tick_pre),
    .tick_out (tick_core)
  );

  adcclk_window #(.ACQ_W(ACQ_W)) u_win (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_core),
    .acq_in (acq_len),
    .req    (sample_req),
    .win    (sample_win),
    .done   (sample_done)
  );

  always_ff @(posedge clk) begin
    if (rst) core_en <= 1'b0;
    else     core_en <= tick_core;
  end

  // R6: a window opens together with a core enable pulse
  a_r6_open_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_win) |-> core_en);

  // R7: completion strobe coincides with a core enable pulse
  a_r7_done_aligned: assert property (@(posedge clk) disable iff (rst)
    sample_done |-> core_en);

endmodule

// File: tb/adcclk_sampler_test.sv
`timescale 1ns/1ps
module adcclk_sampler_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pre_div = '0;
  logic       post_half = 1'b0;
  logic [3:0] acq_len = '0;
  logic       sample_req = 1'b0;
  logic       core_en, sample_win, sample_done;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  adcclk_sampler uut (
    .clk(clk), .rst(rst), .pre_div(pre_div), .post_half(post_half),
    .acq_len(acq_len), .sample_req(sample_req), .core_en(core_en),
    .sample_win(sample_win), .sample_done(sample_done)
  );

  function automatic int ratio_of(int p, int h);
    int r;
    r = (p == 0) ? 1 : 2 * p;
    return h ? 2 * r : r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!core_en);
  endtask

  task automatic set_cfg(input int p, input int h, input int a);
    pre_div = 4'(p); post_half = h[0]; acq_len = 4'(a);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 core_en in reset", core_en, 0);
    chk("R1 sample_win in reset", sample_win, 0);
    chk("R1 sample_done in reset", sample_done, 0);
    rst = 1'b0;
  endtask

  task automatic t_period(input int p, input int h, input string tag);
    int n;
    set_cfg(p, h, 0);
    wait_pulse();
    n = 0;
    do begin @(negedge clk); n++; end while (!core_en);
    chk(tag, n, ratio_of(p, h));
    n = 0;
    do begin @(negedge clk); n++; end while (!core_en);
    chk(tag, n, ratio_of(p, h));
  endtask

  task automatic t_bypass();
    set_cfg(0, 0, 0);
    wait_pulse();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 core_en every cycle", core_en, 1);
    end
  endtask

  task automatic t_cfg_switch();
    int n;
    set_cfg(2, 0, 0);
    wait_pulse();
    wait_pulse();
    set_cfg(5, 0, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!core_en);
    chk("R5 interval after change keeps old ratio", n, 4);
    n = 0;
    do begin @(negedge clk); n++; end while (!core_en);
    chk("R5 next interval uses new ratio", n, 10);
  endtask

  task automatic t_window(input int p, input int h, input int a);
    int n, len, r;
    r = ratio_of(p, h);
    set_cfg(p, h, a);
    wait_pulse();
    sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
    n = 1;
    while (!sample_win) begin @(negedge clk); n++; end
    chk("R10 open latency", n, r);
    chk("R6 open on core boundary", core_en, 1);
    len = 0;
    while (sample_win) begin len++; @(negedge clk); end
    chk("R6 window length", len, (a + 1) * r);
    chk("R7 done at close", sample_done, 1);
    chk("R7 close on core boundary", core_en, 1);
    @(negedge clk);
    chk("R7 done lasts one cycle", sample_done, 0);
  endtask

  task automatic t_merge();
    int len, dones;
    set_cfg(1, 0, 1);
    wait_pulse();
    sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
    while (!sample_win) @(negedge clk);
    len = 0; dones = 0;
    while (sample_win) begin
      if (sample_done) dones++;
      sample_req = (len == 1 || len == 2);
      len++;
      @(negedge clk);
    end
    sample_req = 1'b0;
    chk("R8 merged restart total length", len, 8);
    chk("R8 done at restart", dones, 1);
    chk("R8 done at final close", sample_done, 1);
  endtask

  task automatic t_acq_change();
    int len;
    set_cfg(0, 0, 2);
    wait_pulse();
    sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
    while (!sample_win) @(negedge clk);
    acq_len = 4'd7;
    len = 0;
    while (sample_win) begin len++; @(negedge clk); end
    chk("R9 length fixed at open", len, 3);
    acq_len = 4'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_period(0, 0, "R2 ratio 1");
    t_period(3, 0, "R3 ratio 6");
    t_period(15, 0, "R3 ratio 30");
    t_period(0, 1, "R4 ratio 2");
    t_period(5, 1, "R4 ratio 20");
    t_period(15, 1, "R4 ratio 60");
    t_cfg_switch();
    t_window(0, 0, 3);
    t_window(2, 1, 5);
    t_window(15, 1, 15);
    t_merge();
    t_acq_change();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule